// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns the burst fields of a programmed SDRAM mode word into a stream of column addresses. It holds a small copy of the burst length code, the order select and the single-write select. Each column command is given as a start strobe with a starting column and a read/write flag. From that command the block produces one column address per clock for every beat of the burst. With each address it also gives a beat-valid flag and a last-beat flag.

Lengths 1, 2, 4 and 8 wrap inside an aligned block of that size. The beats can follow either sequential order or XOR-interleave order. A full-page burst walks the whole 256-column row, wraps from the top column to zero, and keeps running until a stop arrives. A new start strobe may come on any clock, including in the middle of a burst. Command decoding, data movement and DQ timing belong to neighbouring blocks.

Top module: `sdram_burst_colgen`

## Requirements
- R1: The length code selects the beat count: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page. In the bench mode word the code sits in bits [2:0].
- R2: In sequential order (order select 0, bit 3 of the mode word), beat i carries the upper column bits of the start unchanged. Its low bits are (start + i) modulo the burst length. For example, length 4 from 1 gives 1,2,3,0.
- R3: In interleave order (order select 1), beat i has the upper bits of the start and low bits equal to (start XOR i). For example, length 8 from 6 gives 6,7,4,5,2,3,0,1.
- R4: A full-page burst steps through columns modulo 256 and wraps from 255 to 0. It runs until stopped, and its last-beat flag never asserts.
- R5: Beat 0 appears on the clock after the start strobe, carrying the start column. beat_valid stays high on every following clock of the burst.
- R6: beat_last is high exactly on the final beat of a fixed-length burst. beat_valid is low on the next clock unless a new start arrived.
- R7: A stop sampled with no start ends any burst. beat_valid is low on the next clock.
- R8: With single-write select set (bit 9 of the mode word), a write start gives a one-beat burst whatever the length code. A read start still uses the full length.
- R9: A start strobe during a burst abandons the current burst. The next clock shows beat 0 of the new burst.
- R10: A reserved length code is treated as length 1 and sets the sticky mode_err on the next clock. Full page combined with interleave also counts as reserved. Only reset clears mode_err.
- R11: After reset, beat_valid, beat_last, mode_err and col_addr are 0, and the mode is length 1 in sequential order.
- R12: A mode load affects only starts on later clocks. A burst already running keeps the length and order it captured at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Load the burst fields below into the mode copy |
| mode_len_code | input | 3 | Burst length code |
| mode_interleave | input | 1 | 0 sequential, 1 interleave |
| mode_write_single | input | 1 | Writes are one beat, reads burst |
| start | input | 1 | Column command strobe |
| start_wr | input | 1 | Command is a write |
| start_col | input | COL_W | Starting column |
| stop | input | 1 | Burst stop |
| col_addr | output | COL_W | Column of the current beat (0 when idle) |
| beat_valid | output | 1 | A beat is presented this clock |
| beat_last | output | 1 | Final beat of a fixed-length burst |
| mode_err | output | 1 | Sticky reserved-code flag |

## Verification
The assertions assume that the start, stop and mode inputs are driven cleanly in the cycle after reset is released. The step check assumes the burst is not cut by a start or a stop in the same cycle, so each of those is excluded in the antecedent. The bench changes inputs only on falling edges, raises each strobe for exactly one clock, and lets every burst finish or stop before it checks the idle state. Mid-burst restarts and mode loads are the only overlaps it drives on purpose.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

  typedef enum logic [2:0] {
    KIND_1    = 3'd0,
    KIND_2    = 3'd1,
    KIND_4    = 3'd2,
    KIND_8    = 3'd3,
    KIND_PAGE = 3'd4
  } burst_kind_e;

  typedef struct packed {
    burst_kind_e kind;
    logic        bad;
  } len_dec_t;

  // Length code decode; full page is legal only in sequential order.
  function automatic len_dec_t decode_len(input logic [2:0] code, input logic interleave);
    len_dec_t d;
    d.bad = 1'b0;
    case (code)
      3'b000:  d.kind = KIND_1;
      3'b001:  d.kind = KIND_2;
      3'b010:  d.kind = KIND_4;
      3'b011:  d.kind = KIND_8;
      3'b111: begin
        d.kind = interleave ? KIND_1 : KIND_PAGE;
        d.bad  = interleave;
      end
      default: begin
        d.kind = KIND_1;
        d.bad  = 1'b1;
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/sdram_mode_copy.sv
module sdram_mode_copy
  import sdram_burst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [2:0]  len_code,
  input  logic        interleave,
  input  logic        write_single,
  output burst_kind_e kind_q,
  output logic        il_q,
  output logic        ws_q,
  output logic        err_q
);

  len_dec_t dec;
  assign dec = decode_len(len_code, interleave);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= KIND_1;
      il_q   <= 1'b0;
      ws_q   <= 1'b0;
      err_q  <= 1'b0;
    end else if (load) begin
      kind_q <= dec.kind;
      il_q   <= interleave & ~dec.bad;
      ws_q   <= write_single;
      err_q  <= err_q | dec.bad;
    end
  end

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  p_reserved_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (len_code inside {3'b100, 3'b101, 3'b110})) |=> err_q && kind_q == KIND_1);

endmodule

// File: rtl/sdram_beat_seq.sv
module sdram_beat_seq
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  burst_kind_e      kind,
  input  logic             interleave,
  input  logic             stop,
  output logic             active,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] idx_q,
  output logic [COL_W-1:0] mask_q,
  output logic             il_q,
  output logic             page_q,
  output logic             last
);

  function automatic logic [COL_W-1:0] kind_mask(input burst_kind_e k);
    case (k)
      KIND_1:  return '0;
      KIND_2:  return COL_W'(1);
      KIND_4:  return COL_W'(3);
      KIND_8:  return COL_W'(7);
      default: return '1;
    endcase
  endfunction

  assign last = active && !page_q && (idx_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      mask_q <= '0;
      il_q   <= 1'b0;
      page_q <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      base_q <= start_col;
      idx_q  <= '0;
      mask_q <= kind_mask(kind);
      il_q   <= interleave;
      page_q <= (kind == KIND_PAGE);
    end else if (active) begin
      if (stop || last) active <= 1'b0;
      else              idx_q  <= idx_q + 1'b1;
    end
  end

  p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !active);

  p_last_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !active);

  p_page_no_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && page_q && !start && !stop) |=> active);

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active && idx_q == '0);

endmodule

// File: rtl/sdram_col_calc.sv
module sdram_col_calc #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             interleave,
  input  logic             active,
  output logic [COL_W-1:0] col
);

  function automatic logic [COL_W-1:0] beat_col(
    input logic [COL_W-1:0] b, input logic [COL_W-1:0] i,
    input logic [COL_W-1:0] m, input logic il);
    logic [COL_W-1:0] lo;
    lo = il ? (b ^ i) : (b + i);
    return (b & ~m) | (lo & m);
  endfunction

  assign col = active ? beat_col(base, idx, mask, interleave) : '0;

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [2:0]       mode_len_code,
  input  logic             mode_interleave,
  input  logic             mode_write_single,
  input  logic             start,
  input  logic             start_wr,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic [COL_W-1:0] col_addr,
  output logic             beat_valid,
  output logic             beat_last,
  output logic             mode_err
);

  burst_kind_e      cfg_kind, eff_kind;
  logic             cfg_il, cfg_ws;
  logic             seq_active, seq_il, seq_page, seq_last;
  logic [COL_W-1:0] seq_base, seq_idx, seq_mask;
  logic             force_single;

  sdram_mode_copy u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (mode_load),
    .len_code     (mode_len_code),
    .interleave   (mode_interleave),
    .write_single (mode_write_single),
    .kind_q       (cfg_kind),
    .il_q         (cfg_il),
    .ws_q         (cfg_ws),
    .err_q        (mode_err)
  );

  assign force_single = cfg_ws && start_wr;
  assign eff_kind     = force_single ? KIND_1 : cfg_kind;

  sdram_beat_seq #(.COL_W(COL_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_col  (start_col),
    .kind       (eff_kind),
    .interleave (cfg_il),
    .stop       (stop),
    .active     (seq_active),
    .base_q     (seq_base),
    .idx_q      (seq_idx),
    .mask_q     (seq_mask),
    .il_q       (seq_il),
    .page_q     (seq_page),
    .last       (seq_last)
  );

  sdram_col_calc #(.COL_W(COL_W)) u_calc (
    .base       (seq_base),
    .idx        (seq_idx),
    .mask       (seq_mask),
    .interleave (seq_il),
    .active     (seq_active),
    .col        (col_addr)
  );

  assign beat_valid = seq_active;
  assign beat_last  = seq_last;

  p_start_beat0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> beat_valid && col_addr == $past(start_col));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last && !seq_il && !start && !stop)
      |=> ((col_addr - $past(col_addr)) & seq_mask) == COL_W'(1));

  p_wsingle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_wr && cfg_ws) |=> beat_last);

  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid && !seq_page);

  p_idle_col_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> col_addr == '0);

endmodule

// File: tb/sdram_burst_colgen_tb_top.sv
module sdram_burst_colgen_tb_top;

  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_load = 1'b0;
  logic [2:0]       mode_len_code = 3'b000;
  logic             mode_interleave = 1'b0;
  logic             mode_write_single = 1'b0;
  logic             start = 1'b0;
  logic             start_wr = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             stop = 1'b0;
  logic [COL_W-1:0] col_addr;
  logic             beat_valid, beat_last, mode_err;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) dut_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .mode_load         (mode_load),
    .mode_len_code     (mode_len_code),
    .mode_interleave   (mode_interleave),
    .mode_write_single (mode_write_single),
    .start             (start),
    .start_wr          (start_wr),
    .start_col         (start_col),
    .stop              (stop),
    .col_addr          (col_addr),
    .beat_valid        (beat_valid),
    .beat_last         (beat_last),
    .mode_err          (mode_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected column: own formulation via block base plus offset.
  function automatic int exp_col(input int col, input int len, input bit il, input int i);
    int blk, off;
    if (len == 256) return (col + i) % 256;
    blk = (col / len) * len;
    off = col % len;
    return il ? blk + (off ^ i) : blk + ((off + i) % len);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  // Mode word: code in [2:0], order in bit 3, single-write in bit 9.
  task automatic load_mode(input logic [11:0] word);
    @(negedge clk);
    mode_load = 1'b1;
    mode_len_code = word[2:0];
    mode_interleave = word[3];
    mode_write_single = word[9];
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  task automatic burst_check(input string req, input int col, input bit wr,
                             input int len, input bit il);
    @(negedge clk);
    start = 1'b1; start_col = COL_W'(col); start_wr = wr;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < len; i++) begin
      chk({req, " valid"}, beat_valid, 1);
      chk({req, " col"}, col_addr, exp_col(col, len, il, i));
      chk({req, " last"}, beat_last, (i == len - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk({req, " idle after burst"}, beat_valid, 0);
  endtask

  task automatic t_reset();
    chk("R11 valid", beat_valid, 0);
    chk("R11 last", beat_last, 0);
    chk("R11 err", mode_err, 0);
    chk("R11 col", col_addr, 0);
    burst_check("R11 default len1", 77, 1'b0, 1, 1'b0);
  endtask

  task automatic t_sequential();
    load_mode(12'h002); burst_check("R2 R1 len4 from1", 1, 1'b0, 4, 1'b0);
    load_mode(12'h003); burst_check("R2 R1 len8 from5", 5, 1'b0, 8, 1'b0);
    load_mode(12'h001); burst_check("R2 R1 len2 from7", 7, 1'b0, 2, 1'b0);
    load_mode(12'h000); burst_check("R1 len1 from9", 9, 1'b0, 1, 1'b0);
    load_mode(12'h003); burst_check("R2 R5 R6 len8 from 0xAB", 8'hAB, 1'b0, 8, 1'b0);
  endtask

  task automatic t_interleave();
    load_mode(12'h00A); burst_check("R3 len4 from2", 2, 1'b0, 4, 1'b1);
    load_mode(12'h00B); burst_check("R3 len8 from6", 6, 1'b0, 8, 1'b1);
    burst_check("R3 len8 from 0x2B", 8'h2B, 1'b0, 8, 1'b1);
    load_mode(12'h009); burst_check("R3 len2 from 0x11", 8'h11, 1'b0, 2, 1'b1);
  endtask

  task automatic t_page();
    int seen_last = 0;
    load_mode(12'h007);
    @(negedge clk); start = 1'b1; start_col = 8'd250; start_wr = 1'b0;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 300; i++) begin
      chk("R4 page valid", beat_valid, 1);
      chk("R4 page col", col_addr, (250 + i) % 256);
      if (beat_last) seen_last++;
      if (i == 299) stop = 1'b1;
      @(negedge clk);
    end
    stop = 1'b0;
    chk("R4 no last in page", seen_last, 0);
    chk("R7 page stopped", beat_valid, 0);
  endtask

  task automatic t_stop();
    load_mode(12'h003);
    @(negedge clk); start = 1'b1; start_col = 8'd16;
    @(negedge clk); start = 1'b0;
    chk("R7 beat0", col_addr, 16);
    @(negedge clk);
    chk("R7 beat1", col_addr, 17);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R7 ended valid", beat_valid, 0);
    chk("R7 ended last", beat_last, 0);
  endtask

  task automatic t_restart();
    load_mode(12'h003);
    @(negedge clk); start = 1'b1; start_col = 8'd0;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 old beat2", col_addr, 2);
    start = 1'b1; start_col = 8'd21;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk("R9 new burst col", col_addr, exp_col(21, 8, 1'b0, i));
      chk("R9 new burst last", beat_last, (i == 7) ? 1 : 0);
      @(negedge clk);
    end
    chk("R9 idle", beat_valid, 0);
  endtask

  task automatic t_write_single();
    load_mode(12'h203);
    burst_check("R8 write single", 8'h35, 1'b1, 1, 1'b0);
    burst_check("R8 read bursts", 8'h35, 1'b0, 8, 1'b0);
    load_mode(12'h003);
    burst_check("R8 write bursts when clear", 8'h35, 1'b1, 8, 1'b0);
  endtask

  task automatic t_mode_change();
    load_mode(12'h003);
    @(negedge clk); start = 1'b1; start_col = 8'd40;
    @(negedge clk); start = 1'b0;
    mode_load = 1'b1; mode_len_code = 3'b001; mode_interleave = 1'b1;
    for (int i = 0; i < 8; i++) begin
      chk("R12 running keeps len/order", col_addr, 40 + i);
      chk("R12 running last", beat_last, (i == 7) ? 1 : 0);
      @(negedge clk);
      mode_load = 1'b0;
    end
    chk("R12 idle", beat_valid, 0);
    burst_check("R12 new mode used", 8'd43, 1'b0, 2, 1'b1);
  endtask

  task automatic t_reserved();
    do_reset();
    load_mode(12'h00F);
    chk("R10 page+interleave err", mode_err, 1);
    burst_check("R10 page+interleave len1", 8'd40, 1'b0, 1, 1'b0);
    load_mode(12'h002);
    chk("R10 err sticky", mode_err, 1);
    burst_check("R10 valid code after err", 8'd6, 1'b0, 4, 1'b0);
    do_reset();
    chk("R10 R11 err cleared by reset", mode_err, 0);
    load_mode(12'h005);
    chk("R10 code 101 err", mode_err, 1);
    burst_check("R10 code 101 len1", 8'd13, 1'b0, 1, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sequential();
    t_interleave();
    t_page();
    t_stop();
    t_restart();
    t_write_single();
    t_mode_change();
    t_reserved();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule